// File: doc/BRIEF.md
# Byte-Pair Configuration Register Slave

This block is a two-wire serial slave that lets a host controller reach a small set of configuration registers. It answers a 7-bit device address whose upper five bits are fixed at binary 10110 and whose two low bits come from board strap inputs. The bus lines are brought into the system clock domain through a short synchroniser. SDA is driven open-drain: the block only pulls the line low.

In a write transfer the address byte is followed by any number of register-select/data byte pairs. The slave acknowledges every byte the host sends. Each data byte that lands on a known register select raises a single-cycle write strobe for that register, with the byte on a shared data bus. A read transfer has no register-select phase. Straight after acknowledging the address, the slave sends the low configuration byte, the high configuration byte and an identification byte, in that order. It keeps cycling through them for as long as the host acknowledges.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {10110, dev_sel[1:0]}, with the R/W flag in bit 0. For any other address it leaves SDA released and ignores the bus until the next start condition.
- R2: In a write transfer (bit 0 = 0), each register-select byte is followed by one data byte. When the data byte completes, exactly one single-cycle strobe fires with the byte on wr_data: wr_lo_stb for select 0x00, wr_hi_stb for 0x01, wr_cmd_stb for 0xF0.
- R3: A single write transfer may carry any number of pairs in any order. The strobes appear in the order the pairs were sent.
- R4: A pair whose select is not 0x00, 0x01 or 0xF0 is acknowledged in both bytes and produces no strobe. The pairs that follow it stay aligned.
- R5: In an addressed write, every byte from the host, including the address, is acknowledged by driving SDA low during the ninth clock.
- R6: In a read transfer (bit 0 = 1), after the address acknowledge the slave sends rd_lo, then rd_hi, then rd_id, most significant bit first. It wraps back to rd_lo while the host keeps acknowledging.
- R7: A host NACK on a read byte releases SDA for the rest of the transfer. A stop condition always releases SDA.
- R8: A start or stop condition at any point, including mid-byte, discards the partial byte and the register select in progress. A start begins a fresh address phase.
- R9: sda_oe changes only after a detected SCL falling edge, or on a start/stop release, so SDA is steady while SCL is high. Data is taken on the SCL rising edge.
- R10: After reset sda_oe is low and all strobes are low.
- R11: No two write strobes are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_sel | input | 2 | Strap value for the two low address bits |
| rd_lo | input | 8 | First byte of the read stream |
| rd_hi | input | 8 | Second byte of the read stream |
| rd_id | input | 8 | Identification byte, third in the read stream |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_lo_stb | output | 1 | Write strobe for select 0x00 |
| wr_hi_stb | output | 1 | Write strobe for select 0x01 |
| wr_cmd_stb | output | 1 | Write strobe for select 0xF0 |
| wr_data | output | 8 | Data byte for the strobed register |

## Verification
Writes are sent as long transfers that mix all three known selects in a scrambled order, with unknown selects placed between valid pairs. This separates proper pair alignment from a design that just counts bytes. The address phase is tried with a strap mismatch and with a prefix mismatch, and then again after the straps change. This shows that both parts of the compare matter. Reads run past the identification byte to expose the wrap order, and also end early with a NACK where the next bit would pull SDA low, which shows whether SDA is truly released. Starts and stops are placed inside half-sent bytes to show that a stale select or partial byte is not carried into the next transfer.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  localparam int BYTE_W   = 8;
  localparam int STRAP_W  = 2;
  localparam int PREFIX_W = 7 - STRAP_W;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam int RD_LEN   = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_DATA, ST_ACK, ST_TX, ST_RACK
  } eng_state_t;

  typedef enum logic [1:0] {TGT_NONE, TGT_LO, TGT_HI, TGT_CMD} reg_tgt_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [PREFIX_W-1:0] prefix,
                                    input logic [STRAP_W-1:0] strap);
    return b[BYTE_W-1:1] == {prefix, strap};
  endfunction

  function automatic reg_tgt_t reg_decode(input logic [BYTE_W-1:0] sel,
                                          input logic [BYTE_W-1:0] a_lo,
                                          input logic [BYTE_W-1:0] a_hi,
                                          input logic [BYTE_W-1:0] a_cmd);
    if (sel == a_lo)  return TGT_LO;
    if (sel == a_hi)  return TGT_HI;
    if (sel == a_cmd) return TGT_CMD;
    return TGT_NONE;
  endfunction

  function automatic logic [1:0] next_idx(input logic [1:0] i);
    return (i == 2'(RD_LEN - 1)) ? 2'd0 : i + 2'd1;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [1:0] i,
                                                  input logic [BYTE_W-1:0] lo,
                                                  input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] id);
    case (i)
      2'd0:    return lo;
      2'd1:    return hi;
      default: return id;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_p     <= scl_chain[STAGES-1];
      sda_p     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  assert_start_stop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  assert_cond_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> !(scl_rise || scl_fall));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] DEV_PREFIX = 5'b10110,
  parameter logic [BYTE_W-1:0]   SEL_LO     = 8'h00,
  parameter logic [BYTE_W-1:0]   SEL_HI     = 8'h01,
  parameter logic [BYTE_W-1:0]   SEL_CMD    = 8'hF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_lo,
  input  logic [BYTE_W-1:0]  rd_hi,
  input  logic [BYTE_W-1:0]  rd_id,
  output logic               sda_oe,
  output logic               wr_lo_stb,
  output logic               wr_hi_stb,
  output logic               wr_cmd_stb,
  output logic [BYTE_W-1:0]  wr_data
);

  eng_state_t        state, after;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, reg_ptr;
  logic [1:0]        rd_idx;
  logic              host_acked;

  // named events for the checks below
  logic              rx_full;
  logic              rx_state;
  logic              byte_close;
  logic              host_nack;
  reg_tgt_t          cur_tgt;
  logic [BYTE_W-1:0] tx_pick;

  assign rx_full    = (bitcnt == CNT_W'(BYTE_W));
  assign rx_state   = (state == ST_ADDR) || (state == ST_REG) || (state == ST_DATA);
  assign byte_close = rx_state && scl_fall && rx_full;
  assign host_nack  = (state == ST_RACK) && scl_rise && sda_s;
  assign cur_tgt    = reg_decode(reg_ptr, SEL_LO, SEL_HI, SEL_CMD);
  assign tx_pick    = pick_byte(rd_idx, rd_lo, rd_hi, rd_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      after      <= ST_IDLE;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      reg_ptr    <= '0;
      rd_idx     <= '0;
      host_acked <= 1'b0;
      sda_oe     <= 1'b0;
      wr_lo_stb  <= 1'b0;
      wr_hi_stb  <= 1'b0;
      wr_cmd_stb <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_lo_stb  <= 1'b0;
      wr_hi_stb  <= 1'b0;
      wr_cmd_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_REG, ST_DATA: begin
            if (scl_rise && !rx_full) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_close) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit(rx_sh, DEV_PREFIX, strap)) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  after  <= rx_sh[0] ? ST_TX : ST_REG;
                  rd_idx <= '0;
                end else begin
                  state  <= ST_IDLE;
                end
              end else if (state == ST_REG) begin
                reg_ptr <= rx_sh;
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
                after   <= ST_DATA;
              end else begin
                wr_data    <= rx_sh;
                wr_lo_stb  <= (cur_tgt == TGT_LO);
                wr_hi_stb  <= (cur_tgt == TGT_HI);
                wr_cmd_stb <= (cur_tgt == TGT_CMD);
                sda_oe     <= 1'b1;
                state      <= ST_ACK;
                after      <= ST_REG;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (after == ST_TX) begin
                sda_oe <= ~tx_pick[BYTE_W-1];
                tx_sh  <= {tx_pick[BYTE_W-2:0], 1'b0};
                rd_idx <= next_idx(rd_idx);
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= after;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (rx_full) begin
                sda_oe     <= 1'b0;
                host_acked <= 1'b0;
                state      <= ST_RACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (host_nack) begin
              state <= ST_IDLE;
            end else if (scl_rise) begin
              host_acked <= 1'b1;
            end else if (scl_fall && host_acked) begin
              sda_oe <= ~tx_pick[BYTE_W-1];
              tx_sh  <= {tx_pick[BYTE_W-2:0], 1'b0};
              rd_idx <= next_idx(rd_idx);
              bitcnt <= '0;
              state  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: SDA output only moves after a seen SCL fall or a start/stop release
  assert_oe_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo_stb, wr_hi_stb, wr_cmd_stb}));

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_stb || wr_hi_stb || wr_cmd_stb) |=> !(wr_lo_stb || wr_hi_stb || wr_cmd_stb));

  assert_strobe_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_stb || wr_hi_stb || wr_cmd_stb) |-> $past(scl_fall));

  assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_nack |=> !sda_oe);

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR) && (bitcnt == '0));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] DEV_PREFIX  = 5'b10110,
  parameter logic [BYTE_W-1:0]   SEL_LO      = 8'h00,
  parameter logic [BYTE_W-1:0]   SEL_HI      = 8'h01,
  parameter logic [BYTE_W-1:0]   SEL_CMD     = 8'hF0,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        dev_sel,
  input  logic [7:0]        rd_lo,
  input  logic [7:0]        rd_hi,
  input  logic [7:0]        rd_id,
  output logic              sda_oe,
  output logic              wr_lo_stb,
  output logic              wr_hi_stb,
  output logic              wr_cmd_stb,
  output logic [7:0]        wr_data
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_engine #(
    .DEV_PREFIX (DEV_PREFIX),
    .SEL_LO     (SEL_LO),
    .SEL_HI     (SEL_HI),
    .SEL_CMD    (SEL_CMD)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap      (dev_sel),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .rd_id      (rd_id),
    .sda_oe     (sda_oe),
    .wr_lo_stb  (wr_lo_stb),
    .wr_hi_stb  (wr_hi_stb),
    .wr_cmd_stb (wr_cmd_stb),
    .wr_data    (wr_data)
  );

  // R9: while SCL is high (synchronised) and no start/stop is seen, SDA output is steady
  assert_sda_steady_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_s) && scl_s && !$past(start_det) && !$past(stop_det) && !$past(scl_fall))
      |-> $stable(sda_oe));

endmodule

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;

  localparam int Q = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1, sda_h = 1'b1;
  logic [1:0] dev_sel = 2'b10;
  logic [7:0] rd_lo = 8'h5C, rd_hi = 8'h81, rd_id = 8'hE3;
  logic       sda_oe, wr_lo_stb, wr_hi_stb, wr_cmd_stb;
  logic [7:0] wr_data;
  wire        sda_line = sda_h & ~sda_oe;

  cfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .dev_sel(dev_sel),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_id(rd_id), .sda_oe(sda_oe),
    .wr_lo_stb(wr_lo_stb), .wr_hi_stb(wr_hi_stb), .wr_cmd_stb(wr_cmd_stb), .wr_data(wr_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // per-clock model comparison of the SDA drive while SCL is high
  logic mon_en = 1'b0, mon_exp = 1'b0;
  int   mon_err = 0;
  always @(negedge clk)
    if (rst_n && mon_en && (sda_oe !== mon_exp)) mon_err++;

  // strobe monitor: code = 0x000/0x100/0x200 + data; 0xFFF if several at once (R11)
  int obs[$];
  int exq[$];
  always @(negedge clk) begin
    if (rst_n) begin
      if ((wr_lo_stb + wr_hi_stb + wr_cmd_stb) > 1) obs.push_back(32'hFFF);
      else if (wr_lo_stb)  obs.push_back(32'h000 + wr_data);
      else if (wr_hi_stb)  obs.push_back(32'h100 + wr_data);
      else if (wr_cmd_stb) obs.push_back(32'h200 + wr_data);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, input logic exp_oe, output logic seen);
    wclk(Q/2); sda_h = b; wclk(Q/2);
    scl_h = 1'b1; wclk(2);
    mon_exp = exp_oe; mon_en = 1'b1;
    wclk(Q-4); seen = sda_line; mon_en = 1'b0;
    wclk(2); scl_h = 1'b0;
  endtask

  task automatic bus_start;
    wclk(Q/2); sda_h = 1'b1; wclk(Q/2);
    scl_h = 1'b1; wclk(Q); sda_h = 1'b0; wclk(Q); scl_h = 1'b0;
  endtask

  task automatic bus_stop;
    wclk(Q/2); sda_h = 1'b0; wclk(Q/2);
    scl_h = 1'b1; wclk(Q); sda_h = 1'b1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, s);
    bus_bit(1'b1, exp_ack, ack);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic host_nak, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, ~exp[i], s);
      v[i] = s;
    end
    bus_bit(host_nak, 1'b0, s);
  endtask

  task automatic chk_strobes(input string req);
    chk(obs.size() == exq.size(), req, "strobe count", obs.size(), exq.size());
    for (int i = 0; i < exq.size(); i++)
      if (i < obs.size()) chk(obs[i] == exq[i], req, "strobe code", obs[i], exq[i]);
    obs.delete(); exq.delete();
  endtask

  task automatic chk_mon(input string req);
    chk(mon_err == 0, req, "sda drive mismatches", mon_err, 0);
    mon_err = 0;
  endtask

  function automatic logic [7:0] dev_byte(input logic [1:0] s, input logic rw);
    return {5'b10110, s, rw};
  endfunction

  task automatic write_pair(input logic [7:0] sel, input logic [7:0] d, input string req);
    logic a;
    send_byte(sel, 1'b1, a); chk(a == 1'b0, req, "select ack", a, 0);
    send_byte(d, 1'b1, a);   chk(a == 1'b0, req, "data ack", a, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a, s;
    logic [7:0] v;
    wclk(5);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10", "sda_oe in reset", sda_oe, 0);
    chk({wr_lo_stb, wr_hi_stb, wr_cmd_stb} == 3'b000, "R10", "strobes in reset",
        {wr_lo_stb, wr_hi_stb, wr_cmd_stb}, 0);
    rst_n = 1'b1; wclk(5);
    chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);

    // R1 R2 R3 R5: mixed-order pairs in one transfer
    bus_start;
    send_byte(dev_byte(2'b10, 1'b0), 1'b1, a);
    chk(a == 1'b0, "R1", "address ack", a, 0);
    write_pair(8'h01, 8'h3C, "R5"); exq.push_back(32'h13C);
    write_pair(8'hF0, 8'h02, "R5"); exq.push_back(32'h202);
    write_pair(8'h00, 8'hA5, "R3"); exq.push_back(32'h0A5);
    write_pair(8'h01, 8'h77, "R3"); exq.push_back(32'h177);
    bus_stop; wclk(4);
    chk_strobes("R2");
    chk_mon("R9");

    // R4: unknown selects acked, no strobe, alignment kept
    bus_start;
    send_byte(dev_byte(2'b10, 1'b0), 1'b1, a);
    write_pair(8'h07, 8'h55, "R4");
    write_pair(8'hF1, 8'hAA, "R4");
    write_pair(8'h00, 8'h11, "R4"); exq.push_back(32'h011);
    bus_stop; wclk(4);
    chk_strobes("R4");
    chk_mon("R4");

    // R1: strap mismatch and prefix mismatch ignored
    bus_start;
    send_byte(dev_byte(2'b01, 1'b0), 1'b0, a);
    chk(a == 1'b1, "R1", "strap mismatch nack", a, 1);
    send_byte(8'h00, 1'b0, a); send_byte(8'h99, 1'b0, a);
    chk(a == 1'b1, "R1", "ignored data nack", a, 1);
    bus_stop;
    bus_start;
    send_byte({5'b10111, 2'b10, 1'b0}, 1'b0, a);
    chk(a == 1'b1, "R1", "prefix mismatch nack", a, 1);
    bus_stop; wclk(4);
    chk_strobes("R1");
    chk_mon("R1");

    // R6: read stream with wrap
    bus_start;
    send_byte(dev_byte(2'b10, 1'b1), 1'b1, a);
    chk(a == 1'b0, "R6", "read address ack", a, 0);
    recv_byte(8'h5C, 1'b0, v); chk(v == 8'h5C, "R6", "byte0 lo", v, 8'h5C);
    recv_byte(8'h81, 1'b0, v); chk(v == 8'h81, "R6", "byte1 hi", v, 8'h81);
    recv_byte(8'hE3, 1'b0, v); chk(v == 8'hE3, "R6", "byte2 id", v, 8'hE3);
    recv_byte(8'h5C, 1'b1, v); chk(v == 8'h5C, "R6", "wrap to lo", v, 8'h5C);
    wclk(4);
    chk(sda_oe == 1'b0, "R7", "released after nack", sda_oe, 0);
    bus_stop;
    chk_mon("R6");

    // R7: NACK then further clocks, next byte would pull low
    rd_hi = 8'h01;
    bus_start;
    send_byte(dev_byte(2'b10, 1'b1), 1'b1, a);
    recv_byte(8'h5C, 1'b1, v);
    for (int i = 0; i < 3; i++) begin
      bus_bit(1'b1, 1'b0, s);
      chk(s == 1'b1, "R7", "line after nack", s, 1);
    end
    bus_stop; wclk(4);
    chk(sda_oe == 1'b0, "R7", "released after stop", sda_oe, 0);
    chk_mon("R7");

    // R8: repeated start inside a data byte
    bus_start;
    send_byte(dev_byte(2'b10, 1'b0), 1'b1, a);
    send_byte(8'h01, 1'b1, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, 1'b0, s);
    bus_start;
    send_byte(dev_byte(2'b10, 1'b0), 1'b1, a);
    chk(a == 1'b0, "R8", "ack after repeated start", a, 0);
    write_pair(8'h00, 8'hC3, "R8"); exq.push_back(32'h0C3);
    bus_stop;
    // R8: stop after select, select must not carry over
    bus_start;
    send_byte(dev_byte(2'b10, 1'b0), 1'b1, a);
    send_byte(8'hF0, 1'b1, a);
    bus_stop;
    bus_start;
    send_byte(dev_byte(2'b10, 1'b0), 1'b1, a);
    write_pair(8'h01, 8'h44, "R8"); exq.push_back(32'h144);
    bus_stop; wclk(4);
    chk_strobes("R8");
    chk_mon("R8");

    // R1 R11: new strap value, old one refused
    dev_sel = 2'b01;
    bus_start;
    send_byte(dev_byte(2'b10, 1'b0), 1'b0, a);
    chk(a == 1'b1, "R1", "old strap refused", a, 1);
    bus_stop;
    bus_start;
    send_byte(dev_byte(2'b01, 1'b0), 1'b1, a);
    chk(a == 1'b0, "R1", "new strap ack", a, 0);
    write_pair(8'hF0, 8'h81, "R11"); exq.push_back(32'h281);
    write_pair(8'h00, 8'h00, "R11"); exq.push_back(32'h000);
    bus_stop; wclk(4);
    chk_strobes("R11");
    chk_mon("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule